// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block supervises software through a timer that advances on a slow external watchdog clock. The registers live in the system clock domain. The watchdog clock is synchronised into that domain. Each rising edge becomes one step. As an option, a divide-by-16 prescaler can sit in front of the step logic. A scaler counts steps, and a counter counts scaler wraps. Software reloads both through a program write.

If software does not refresh in time, the block raises a one-cycle interrupt and starts a second period of the same length. A program write during that second period acknowledges it and returns the timer to normal counting. If no write arrives before the second period runs out, the block drives a processor-reset output for a fixed number of system clocks. That reset puts the timer back into its power-on state.

Software can disable the timer once after reset through a trap-door write. After the first program write, the trap door no longer works. While the CPU is halted, all counting stops.

Top module: `wdt_two_stage`

## Requirements
- R1: Each rising edge of `wd_clk` is one step when the prescaler is off. When the prescaler is on, one step is taken per 16 rising edges. The prescaler is controlled by a write with `wr_sel`=2: `wr_data[0]`=1 turns it on. Only system reset clears this bit, which starts off. A program write restarts the prescaler phase.
- R2: A program write is a write with `wr_sel`=0. `wr_data[SCAL_W-1:0]` holds the scaler reload S, and `wr_data[SCAL_W+CNT_W-1:SCAL_W]` holds the counter reload C. Counting restarts, and the interrupt follows after exactly (S+1)*(C+1) steps.
- R3: After system reset the timer is running, with both S and C at their maximum. The first interrupt therefore comes after 2^SCAL_W * 2^CNT_W steps.
- R4: A program write made before expiry reloads the timer. The full period is counted again from the write.
- R5: On expiry in normal counting, `wd_irq` is high for exactly one system clock. A reset-timeout period of (S+1)*(C+1) steps begins at once.
- R6: A program write during the reset-timeout period acknowledges it. No processor reset follows, and the next interrupt comes after the newly written period.
- R7: If the reset-timeout period expires, `cpu_rst` is high for RST_LEN (16) system clocks and no further interrupt is raised. The timer then returns to the power-on state: maximum reloads, trap door usable again.
- R8: A write with `wr_sel`=1 (trap door), made before any program write, stops the timer, so no interrupt occurs. A later program write restarts it with the written values.
- R9: Once a program write has occurred, trap-door writes are ignored and the timer keeps counting.
- R10: While `cpu_halt` is high, steps are not counted and the prescaler does not advance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| wd_clk | input | 1 | Slow watchdog clock, at least 3x slower than clk |
| wr_en | input | 1 | Register write strobe, one cycle |
| wr_sel | input | 2 | Write target: 0 program/acknowledge, 1 trap door, 2 prescaler select |
| wr_data | input | SCAL_W+CNT_W | Write data |
| cpu_halt | input | 1 | CPU halted, freezes counting |
| wd_irq | output | 1 | One-cycle watchdog interrupt |
| cpu_rst | output | 1 | Processor reset, RST_LEN cycles long |

## Verification
The period is tested with several scaler/counter pairs: the power-on maximum, an unbalanced pair (1,2), a scaler-only pair (2,0) and a counter-only pair (0,1). These pairs show whether the two fields are placed and weighted correctly, because each product is distinct. The refresh, acknowledge and silence patterns stop the step sequence one step short of expiry, then cross it, which separates correct reloads from off-by-one errors. Prescaled runs at 15 and 16 edges, and halted runs, show that gating acts on the step rate and not on the reload values.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    WD_OFF   = 2'd0,
    WD_RUN   = 2'd1,
    WD_GRACE = 2'd2
  } wd_state_e;

  localparam logic [1:0] SEL_PROG = 2'd0;
  localparam logic [1:0] SEL_TRAP = 2'd1;
  localparam logic [1:0] SEL_PRE  = 2'd2;
endpackage

// File: rtl/wdt_tick_gen.sv
module wdt_tick_gen #(
  parameter int PRE_DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wd_clk,
  input  logic pre_en,
  input  logic hold,
  input  logic restart,
  output logic tick_o
);
  localparam int PW = (PRE_DIV > 2) ? $clog2(PRE_DIV) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(PRE_DIV - 1);

  logic [2:0]    sync_q;
  logic [PW-1:0] pre_q;
  logic          raw_edge;
  logic          pre_wrap;

  // two-flop synchroniser plus one history flop for edge detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], wd_clk};
  end

  assign raw_edge = sync_q[1] & ~sync_q[2];
  assign pre_wrap = (pre_q == PRE_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             pre_q <= '0;
    else if (restart)                       pre_q <= '0;
    else if (raw_edge && !hold && pre_en)   pre_q <= pre_wrap ? '0 : pre_q + 1'b1;
  end

  assign tick_o = raw_edge && (!pre_en || pre_wrap);

  // R1: an edge of the slow clock yields a single-cycle step
  a_r1_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);

  // R10: prescaler phase frozen while held
  a_r10_pre_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !restart) |=> $stable(pre_q));
endmodule

// File: rtl/wdt_core.sv
module wdt_core
  import wdt_pkg::*;
#(
  parameter int SCAL_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tick,
  input  logic                    halt,
  input  logic                    prog_wr,
  input  logic                    trap_wr,
  input  logic [SCAL_W+CNT_W-1:0] wr_data,
  output logic                    irq_o,
  output logic                    rst_evt_o,
  output wd_state_e               st_o
);
  localparam logic [SCAL_W-1:0] S_MAX = '1;
  localparam logic [CNT_W-1:0]  C_MAX = '1;

  function automatic logic [SCAL_W-1:0] scal_field(input logic [SCAL_W+CNT_W-1:0] d);
    return d[SCAL_W-1:0];
  endfunction

  function automatic logic [CNT_W-1:0] cnt_field(input logic [SCAL_W+CNT_W-1:0] d);
    return d[SCAL_W+CNT_W-1:SCAL_W];
  endfunction

  wd_state_e         st_q;
  logic [SCAL_W-1:0] scal_q, srl_q;
  logic [CNT_W-1:0]  cnt_q, crl_q;
  logic              locked_q;
  logic              irq_q;

  // named internal events
  logic step, scal_zero, cnt_zero, trap_ok, expire, irq_evt, rst_evt;

  assign step      = tick && !halt && (st_q != WD_OFF);
  assign scal_zero = (scal_q == '0);
  assign cnt_zero  = (cnt_q == '0);
  assign trap_ok   = trap_wr && !locked_q;
  assign expire    = step && scal_zero && cnt_zero && !prog_wr && !trap_ok;
  assign irq_evt   = expire && (st_q == WD_RUN);
  assign rst_evt   = expire && (st_q == WD_GRACE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= WD_RUN;
      scal_q   <= S_MAX;
      cnt_q    <= C_MAX;
      srl_q    <= S_MAX;
      crl_q    <= C_MAX;
      locked_q <= 1'b0;
    end else if (prog_wr) begin
      st_q     <= WD_RUN;
      scal_q   <= scal_field(wr_data);
      cnt_q    <= cnt_field(wr_data);
      srl_q    <= scal_field(wr_data);
      crl_q    <= cnt_field(wr_data);
      locked_q <= 1'b1;
    end else if (rst_evt) begin
      st_q     <= WD_RUN;
      scal_q   <= S_MAX;
      cnt_q    <= C_MAX;
      srl_q    <= S_MAX;
      crl_q    <= C_MAX;
      locked_q <= 1'b0;
    end else if (trap_ok) begin
      st_q     <= WD_OFF;
    end else if (step) begin
      if (scal_zero) begin
        scal_q <= srl_q;
        if (cnt_zero) begin
          cnt_q <= crl_q;
          st_q  <= WD_GRACE;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end else begin
        scal_q <= scal_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_evt;
  end

  assign irq_o     = irq_q;
  assign rst_evt_o = rst_evt;
  assign st_o      = st_q;

  // R5: interrupt is a single pulse and coincides with the reset-timeout phase
  a_r5_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);
  a_r5_irq_in_grace: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (st_q == WD_GRACE));
  // R9: after programming the timer is never off
  a_r9_locked_running: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |-> (st_q != WD_OFF));
  a_r9_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && !rst_evt) |=> locked_q);
  // R8: a disabled timer raises nothing
  a_r8_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == WD_OFF && !prog_wr) |=> !irq_o);
  // R10: halt freezes the timer state
  a_r10_halt_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !prog_wr && !trap_wr) |=> ($stable(scal_q) && $stable(cnt_q) && $stable(st_q)));
endmodule

// File: rtl/wdt_rst_stretch.sv
module wdt_rst_stretch #(
  parameter int RST_LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic rst_o
);
  localparam int LW = $clog2(RST_LEN + 1);
  localparam logic [LW-1:0] LEN_V = LW'(RST_LEN);

  logic [LW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            left_q <= '0;
    else if (start)        left_q <= LEN_V;
    else if (left_q != '0) left_q <= left_q - 1'b1;
  end

  assign rst_o = (left_q != '0);

  // R7: reset output follows a start and its length is bounded
  a_r7_start_asserts: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> rst_o);
  a_r7_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
    left_q <= LEN_V);
endmodule

// File: rtl/wdt_two_stage.sv
module wdt_two_stage
  import wdt_pkg::*;
#(
  parameter int SCAL_W  = 8,
  parameter int CNT_W   = 16,
  parameter int PRE_DIV = 16,
  parameter int RST_LEN = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wd_clk,
  input  logic                    wr_en,
  input  logic [1:0]              wr_sel,
  input  logic [SCAL_W+CNT_W-1:0] wr_data,
  input  logic                    cpu_halt,
  output logic                    wd_irq,
  output logic                    cpu_rst
);
  logic      prog_wr, trap_wr, pre_wr;
  logic      pre_en_q;
  logic      tick;
  logic      rst_evt;
  wd_state_e core_st;

  assign prog_wr = wr_en && (wr_sel == SEL_PROG);
  assign trap_wr = wr_en && (wr_sel == SEL_TRAP);
  assign pre_wr  = wr_en && (wr_sel == SEL_PRE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pre_en_q <= 1'b0;
    else if (pre_wr) pre_en_q <= wr_data[0];
  end

  wdt_tick_gen #(.PRE_DIV(PRE_DIV)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .wd_clk (wd_clk),
    .pre_en (pre_en_q),
    .hold   (cpu_halt),
    .restart(prog_wr || rst_evt),
    .tick_o (tick)
  );

  wdt_core #(.SCAL_W(SCAL_W), .CNT_W(CNT_W)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .halt     (cpu_halt),
    .prog_wr  (prog_wr),
    .trap_wr  (trap_wr),
    .wr_data  (wr_data),
    .irq_o    (wd_irq),
    .rst_evt_o(rst_evt),
    .st_o     (core_st)
  );

  wdt_rst_stretch #(.RST_LEN(RST_LEN)) u_stretch (
    .clk  (clk),
    .rst_n(rst_n),
    .start(rst_evt),
    .rst_o(cpu_rst)
  );

  // R7: a processor reset only ever starts out of the reset-timeout phase
  a_r7_from_grace: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_rst) |-> $past(core_st == WD_GRACE));
  // R5: interrupt and processor reset never overlap in onset
  a_r5_irq_not_rst: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_rst) |-> !wd_irq);
endmodule

// File: tb/wdt_two_stage_bench.sv
module wdt_two_stage_bench;
  localparam int SW = 2;
  localparam int CW = 3;
  localparam int DW = SW + CW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wd_clk = 1'b0;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_sel = 2'd0;
  logic [DW-1:0] wr_data = '0;
  logic          cpu_halt = 1'b0;
  logic          wd_irq, cpu_rst;

  int total = 0;
  int bad = 0;
  int irq_cnt = 0;
  int rst_cyc = 0;

  always #2.5 clk = ~clk;

  wdt_two_stage #(.SCAL_W(SW), .CNT_W(CW), .PRE_DIV(16), .RST_LEN(16)) u_wdt_two_stage (
    .clk(clk), .rst_n(rst_n), .wd_clk(wd_clk), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .cpu_halt(cpu_halt), .wd_irq(wd_irq), .cpu_rst(cpu_rst)
  );

  always @(posedge clk) begin
    if (wd_irq)  irq_cnt = irq_cnt + 1;
    if (cpu_rst) rst_cyc = rst_cyc + 1;
  end

  function automatic int period(input int s, input int c);
    int acc = 0;
    for (int k = 0; k <= c; k++) acc += s + 1;
    return acc;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0; cpu_halt = 1'b0; wd_clk = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    irq_cnt = 0; rst_cyc = 0;
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      wd_clk = 1'b1;
      repeat (4) @(negedge clk);
      wd_clk = 1'b0;
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic write(input logic [1:0] sel, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic prog(input int s, input int c);
    logic [SW-1:0] sf = SW'(s);
    logic [CW-1:0] cf = CW'(c);
    write(2'd0, {cf, sf});
  endtask

  task automatic t_reset_default();
    do_reset();
    check("R3 irq low after reset", int'(wd_irq), 0);
    check("R3 cpu_rst low after reset", int'(cpu_rst), 0);
    pulses(period(3, 7) - 1);
    check("R3 no irq before max period", irq_cnt, 0);
    pulses(1);
    check("R3 irq at max period", irq_cnt, 1);
  endtask

  task automatic t_period();
    do_reset();
    prog(1, 2);
    pulses(period(1, 2) - 1);
    check("R2 (1,2) one step early", irq_cnt, 0);
    pulses(1);
    check("R2 (1,2) period", irq_cnt, 1);
    prog(2, 0);
    pulses(period(2, 0) - 1);
    check("R2 (2,0) one step early", irq_cnt, 1);
    pulses(1);
    check("R2 (2,0) period", irq_cnt, 2);
  endtask

  task automatic t_refresh();
    do_reset();
    prog(1, 1);
    pulses(3);
    prog(1, 1);
    pulses(3);
    check("R4 refresh restarts count", irq_cnt, 0);
    pulses(1);
    check("R4 irq after full period from refresh", irq_cnt, 1);
  endtask

  task automatic t_ack();
    do_reset();
    prog(0, 1);
    pulses(2);
    check("R5 irq once on expiry", irq_cnt, 1);
    pulses(1);
    prog(0, 2);
    pulses(2);
    check("R6 no new irq after ack", irq_cnt, 1);
    check("R6 no processor reset after ack", rst_cyc, 0);
    pulses(1);
    check("R6 irq after acknowledged period", irq_cnt, 2);
  endtask

  task automatic t_proc_reset();
    do_reset();
    prog(0, 1);
    pulses(2);
    pulses(1);
    check("R5 grace not over early", rst_cyc, 0);
    pulses(1);
    repeat (20) @(negedge clk);
    check("R7 cpu_rst length", rst_cyc, 16);
    check("R7 no irq at grace expiry", irq_cnt, 1);
    write(2'd1, '0);
    pulses(40);
    check("R7 trap door usable after processor reset", irq_cnt, 1);
  endtask

  task automatic t_trap();
    do_reset();
    write(2'd1, '0);
    pulses(40);
    check("R8 disabled timer silent", irq_cnt, 0);
    prog(0, 1);
    pulses(1);
    check("R8 restarted one step early", irq_cnt, 0);
    pulses(1);
    check("R8 restarted with written values", irq_cnt, 1);
  endtask

  task automatic t_lock();
    do_reset();
    prog(0, 2);
    write(2'd1, '0);
    pulses(2);
    check("R9 one step early", irq_cnt, 0);
    pulses(1);
    check("R9 trap ignored after program", irq_cnt, 1);
  endtask

  task automatic t_halt();
    do_reset();
    prog(0, 2);
    cpu_halt = 1'b1;
    pulses(10);
    check("R10 halted no irq", irq_cnt, 0);
    cpu_halt = 1'b0;
    pulses(2);
    check("R10 count resumes unshifted", irq_cnt, 0);
    pulses(1);
    check("R10 irq after resumed period", irq_cnt, 1);
  endtask

  task automatic t_prescale();
    do_reset();
    write(2'd2, DW'(1));
    prog(0, 0);
    pulses(15);
    check("R1 prescaled one edge early", irq_cnt, 0);
    pulses(1);
    check("R1 prescaled step at 16 edges", irq_cnt, 1);
    pulses(16);
    repeat (20) @(negedge clk);
    check("R1 prescaled grace expiry", rst_cyc, 16);
    do_reset();
    prog(0, 0);
    pulses(1);
    check("R1 prescaler off after system reset", irq_cnt, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset_default();
    t_period();
    t_refresh();
    t_ack();
    t_proc_reset();
    t_trap();
    t_lock();
    t_halt();
    t_prescale();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule